// File: doc/BRIEF.md
# Image Sample FIFO Drain Port

This block sits between an image acquisition front end and a host processor's asynchronous external memory bus. Samples are written into a dual-clock FIFO in the acquisition clock domain. The host drains them by issuing 16-bit reads at one fixed bus address. Each read is qualified by an active-low zone select and an active-low read strobe. The host does not sample a ready line, so the block can never stretch a read cycle.

The select and strobe pins are brought into the read clock domain through two-flop synchronisers. The start of each qualified read pops exactly one word into an output register. That word is offered on the data pins while the host holds the read. The output enable is derived directly from the raw pins, and an external pad turns it into tri-state control. Two flags go to the host as rising-edge interrupts. The full flag starts a DMA drain of 16-word bursts, and the empty flag stops it. A read of an empty FIFO repeats the previous word and sets a sticky underflow indication.

The read clock must be fast enough for the synchroniser delay plus one pop cycle to finish inside the host's lead and active read phases.

Top module: `fifo_drain_port`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0, `underflow_o` is 0 and `bus_oe_o` is 0.
- R2: Words leave the FIFO in the same order they were written. A read returns the oldest unread word on `bus_data_o` within three read-clock rising edges after both `cs_n_i` and `rd_n_i` are low.
- R3: A read that holds `cs_n_i` and `rd_n_i` low for any number of cycles removes exactly one word from the FIFO.
- R4: While `cs_n_i` is high, activity on `rd_n_i` removes no word from the FIFO. While `rd_n_i` is high, activity on `cs_n_i` also removes no word.
- R5: `bus_oe_o` is 1 exactly while `cs_n_i` and `rd_n_i` are both low, and 0 otherwise.
- R6: `full_o` becomes 1 once DEPTH unread words are stored, where DEPTH is 2^ADDR_W and is 32 by default.
- R7: A write attempted while `full_o` is 1 is discarded. After such a write, the FIFO still holds only the original DEPTH words.
- R8: A read while the FIFO is empty returns the previously read word again and does not move the read position. It also sets `underflow_o`, which stays at 1 until reset.
- R9: `empty_o` is 1 whenever all written words have been read. It returns to 0 after new words are written, once they have crossed into the read domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset for both clock domains |
| wclk_i | input | 1 | Acquisition (write) clock |
| wr_en_i | input | 1 | Write request for one sample |
| wr_data_i | input | 16 | Sample to be written |
| full_o | output | 1 | FIFO full, write-clock domain |
| rclk_i | input | 1 | Read-side clock used to sample the host strobes |
| cs_n_i | input | 1 | Host zone select, active low, asynchronous |
| rd_n_i | input | 1 | Host read strobe, active low, asynchronous |
| bus_data_o | output | 16 | Word returned to the host |
| bus_oe_o | output | 1 | Pad drive enable for bus_data_o |
| empty_o | output | 1 | FIFO empty, read-clock domain |
| underflow_o | output | 1 | Sticky flag for a read from an empty FIFO |

## Verification
The hardest situation to reach is the boundary between a full FIFO and an empty one as seen across the two clocks. That boundary includes a write rejected at full and a read taken while empty, which must repeat the last word. The stimulus fills the FIFO with writes until `full_o` is set and then pushes one extra word. It then drains exactly DEPTH words through host read cycles. A final read is made after `empty_o` rises, and it must return the last word once more and raise `underflow_o`. Separate cycles hold the strobe for a long time, and pulse only one of the two select or strobe pins, to show that each qualified read pops exactly one word.

// File: rtl/fdp_pkg.sv
package fdp_pkg;
  function automatic logic [15:0] bin2gray16(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/fdp_sync.sv
module fdp_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/fdp_mem.sv
module fdp_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fdp_wr_side.sv
module fdp_wr_side #(
  parameter int ADDR_W = 5,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] rgray_sync_i,
  output logic             we_o,
  output logic [PTR_W-1:0] wbin_o,
  output logic [PTR_W-1:0] wgray_o,
  output logic             full_o
);
  logic [PTR_W-1:0] bin_q, gray_q, bin_nxt, full_cmp;

  assign full_cmp = {~rgray_sync_i[PTR_W-1:PTR_W-2], rgray_sync_i[PTR_W-3:0]};
  assign full_o   = (gray_q == full_cmp);
  assign we_o     = wr_en_i & ~full_o;
  assign bin_nxt  = bin_q + PTR_W'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (we_o) begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  assign wbin_o  = bin_q;
  assign wgray_o = gray_q;
endmodule

// File: rtl/fdp_rd_slave.sv
module fdp_rd_slave #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic [PTR_W-1:0]  wgray_sync_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [PTR_W-1:0]  rbin_o,
  output logic [PTR_W-1:0]  rgray_o,
  output logic              pop_ev_o,
  output logic              empty_o,
  output logic              underflow_o,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o
);
  logic [1:0] strb_s;
  logic act, act_q, ufl_q;
  logic [PTR_W-1:0] bin_q, gray_q, bin_nxt;
  logic [DATA_W-1:0] data_q;

  fdp_sync #(.W(2), .RST_VAL(2'b11)) u_strb_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i({cs_n_i, rd_n_i}), .q_o(strb_s)
  );

  assign act      = ~strb_s[1] & ~strb_s[0];
  assign pop_ev_o = act & ~act_q;  // leading edge of a qualified read
  assign empty_o  = (gray_q == wgray_sync_i);
  assign bin_nxt  = bin_q + PTR_W'(1);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      bin_q  <= '0;
      gray_q <= '0;
      data_q <= '0;
      ufl_q  <= 1'b0;
    end else begin
      act_q <= act;
      if (pop_ev_o) begin
        if (empty_o) begin
          ufl_q <= 1'b1;  // keep data_q: repeat previous word
        end else begin
          data_q <= mem_rdata_i;
          bin_q  <= bin_nxt;
          gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
      end
    end
  end

  // drive enable follows the raw pins so data appears without sync delay
  assign oe_o        = ~cs_n_i & ~rd_n_i;
  assign data_o      = data_q;
  assign rbin_o      = bin_q;
  assign rgray_o     = gray_q;
  assign underflow_o = ufl_q;
endmodule

// File: rtl/fifo_drain_port.sv
module fifo_drain_port #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              rst_ni,
  input  logic              wclk_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  input  logic              rclk_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o,
  output logic              empty_o,
  output logic              underflow_o
);
  logic             we;
  logic             pop_ev;
  logic [PTR_W-1:0] wr_bin, wr_gray, rd_bin, rd_gray, wgray_rs, rgray_ws;
  logic [DATA_W-1:0] mem_rdata;

  fdp_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .rgray_sync_i(rgray_ws), .we_o(we), .wbin_o(wr_bin),
    .wgray_o(wr_gray), .full_o(full_o)
  );

  fdp_sync #(.W(PTR_W)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rd_gray), .q_o(rgray_ws)
  );

  fdp_sync #(.W(PTR_W)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wr_gray), .q_o(wgray_rs)
  );

  fdp_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(wr_bin[ADDR_W-1:0]),
    .wdata_i(wr_data_i), .raddr_i(rd_bin[ADDR_W-1:0]), .rdata_o(mem_rdata)
  );

  fdp_rd_slave #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .wgray_sync_i(wgray_rs), .mem_rdata_i(mem_rdata), .rbin_o(rd_bin),
    .rgray_o(rd_gray), .pop_ev_o(pop_ev), .empty_o(empty_o),
    .underflow_o(underflow_o), .data_o(bus_data_o), .oe_o(bus_oe_o)
  );
endmodule

// File: rtl/fifo_drain_port_chk.sv
module fifo_drain_port_chk #(
  parameter int PTR_W = 6
) (
  input logic             wclk_i,
  input logic             rclk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             full_o,
  input logic             empty_o,
  input logic             underflow_o,
  input logic             cs_n_i,
  input logic             pop_ev,
  input logic [PTR_W-1:0] wbin,
  input logic [PTR_W-1:0] rbin
);
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (full_o && wr_en_i) |=> $stable(wbin)); // R7
  AST_SINGLE_POP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    pop_ev |=> !pop_ev); // R3
  AST_PTR_ONLY_ON_POP: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !pop_ev |=> $stable(rbin)); // R3
  AST_EMPTY_READ_HOLDS: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (pop_ev && empty_o) |=> (underflow_o && $stable(rbin))); // R8
  AST_UNDERFLOW_STICKY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o); // R8
  AST_NO_POP_WITHOUT_CS: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2)) |-> !pop_ev); // R4
endmodule

bind fifo_drain_port fifo_drain_port_chk #(.PTR_W(ADDR_W + 1)) chk_i (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .full_o(full_o), .empty_o(empty_o), .underflow_o(underflow_o),
  .cs_n_i(cs_n_i), .pop_ev(pop_ev), .wbin(wr_bin), .rbin(rd_bin)
);

// File: tb/fifo_drain_port_tb_top.sv
module fifo_drain_port_tb_top;
  localparam int DEPTH = 32;

  logic rst_ni = 1'b0;
  logic wclk_i = 1'b0;
  logic rclk_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic cs_n_i = 1'b1;
  logic rd_n_i = 1'b1;
  logic full_o, bus_oe_o, empty_o, underflow_o;
  logic [15:0] bus_data_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  logic [15:0] last_word = '0;

  always #2.5 rclk_i = ~rclk_i;  // 200 MHz
  always #3.5 wclk_i = ~wclk_i;

  fifo_drain_port dut_i (
    .rst_ni(rst_ni), .wclk_i(wclk_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .full_o(full_o), .rclk_i(rclk_i), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
    .bus_data_o(bus_data_o), .bus_oe_o(bus_oe_o), .empty_o(empty_o),
    .underflow_o(underflow_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: writes a word, pushes it to the scoreboard if accepted
  task automatic push_word(input logic [15:0] d);
    @(negedge wclk_i);
    if (!full_o) exp_q.push_back(d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge wclk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk_i);
  endtask

  // monitor: one host read cycle, compared against the scoreboard
  task automatic host_read(input string req, input int hold);
    logic [15:0] exp;
    @(negedge rclk_i);
    cs_n_i = 1'b0;
    rd_n_i = 1'b0;
    repeat (hold) @(negedge rclk_i);
    check({req, " oe during read (R5)"}, 32'(bus_oe_o), 32'd1);
    if (exp_q.size() > 0) exp = exp_q.pop_front();
    else exp = last_word;
    check(req, 32'(bus_data_o), 32'(exp));
    last_word = exp;
    cs_n_i = 1'b1;
    rd_n_i = 1'b1;
    repeat (3) @(negedge rclk_i);
    check("R5 oe off after read", 32'(bus_oe_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge rclk_i);
    check("R1 empty", 32'(empty_o), 32'd1);
    check("R1 full", 32'(full_o), 32'd0);
    check("R1 underflow", 32'(underflow_o), 32'd0);
    check("R1 oe", 32'(bus_oe_o), 32'd0);
    rst_ni = 1'b1;
    settle();

    // in-order drain, several patterns
    push_word(16'h1234); push_word(16'hA5A5); push_word(16'h0001); push_word(16'hFFFF);
    settle();
    check("R9 not empty after writes", 32'(empty_o), 32'd0);
    host_read("R2 order", 4);
    host_read("R2 order", 3);
    // long hold pops once
    host_read("R3 long hold", 20);

    // strobe without select, select without strobe
    @(negedge rclk_i); rd_n_i = 1'b0;
    repeat (6) @(negedge rclk_i);
    check("R5 oe with rd only", 32'(bus_oe_o), 32'd0);
    rd_n_i = 1'b1;
    repeat (4) @(negedge rclk_i);
    cs_n_i = 1'b0;
    repeat (6) @(negedge rclk_i);
    check("R5 oe with cs only", 32'(bus_oe_o), 32'd0);
    cs_n_i = 1'b1;
    repeat (4) @(negedge rclk_i);
    host_read("R4 no pop without both", 4);
    settle();
    check("R9 empty after drain", 32'(empty_o), 32'd1);

    // fill to full plus one extra rejected write
    for (int i = 0; i < DEPTH; i++) push_word(16'(16'h3000 + i * 7));
    @(negedge wclk_i);
    check("R6 full at depth", 32'(full_o), 32'd1);
    push_word(16'hDEAD);
    check("R7 queue holds depth", 32'(exp_q.size()), 32'(DEPTH));
    settle();
    for (int i = 0; i < DEPTH; i++) host_read("R7 drain", 4);
    settle();
    check("R7 empty after depth reads", 32'(empty_o), 32'd1);
    repeat (4) @(negedge wclk_i);
    check("R6 full cleared", 32'(full_o), 32'd0);

    // read while empty repeats last word
    host_read("R8 repeat on empty", 4);
    check("R8 underflow set", 32'(underflow_o), 32'd1);
    push_word(16'h5A5A);
    settle();
    host_read("R8 next word after underflow", 4);
    check("R8 underflow sticky", 32'(underflow_o), 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge rclk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule